// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits on the CPU side of a host-to-PCI bridge. It watches a 256 MB address region at 0xF0000000 and splits it into 32 chunks of 8 MB each. For every CPU request it decides whether the address belongs to a chunk that should be passed on to downstream PCI memory space. The decision and the unchanged address come out one clock after the request, so a downstream bus engine can act on them.

Software sets up three registers through a simple write port. The first is a 32-bit chunk enable mask. The second is a 2-bit forwarding mode field. The third is a 2-bit fast back-to-back enable setting, which is handed on to the bus engine as a level. The lowest chunk is always excluded, because it is reserved for boot firmware. The highest chunk is also always excluded, because it holds the bridge's own registers. No mask setting can change either exclusion.

Top module: `owd_window_dec`

## Requirements
- R1: After reset, req_valid_o, fwd_o, addr_o and fbb_en_o are all zero. The mask and mode registers are also zero, so no address is forwarded until software writes them.
- R2: An address whose bits [31:28] are not 0xF never sets fwd_o.
- R3: Inside the region, the chunk index is address bits [27:23]. An address in chunk i, for i from 1 to 30, is forwarded when mask bit i is set and the mode is on. If mask bit i is clear, the address is not forwarded.
- R4: The mode is on only when bits [8:7] of a control write (wr_sel_i = 2'b01) equal 2'b01. The values 2'b00, 2'b10 and 2'b11 block all forwarding. The other bits of the write have no effect.
- R5: Chunk 0 (0xF0000000–0xF07FFFFF) and chunk 31 (0xFF800000–0xFFFFFFFF) are never forwarded, whatever mask bits 0 and 31 hold.
- R6: A write with wr_sel_i = 2'b10 stores only wr_data_i[1:0] into the fast back-to-back enable register, and that value appears on fbb_en_o from the next cycle on.
- R7: A request accepted at a rising edge produces req_valid_o = 1 and addr_o equal to the request address right after that edge. fwd_o is valid in the same cycle.
- R8: A mask or mode write takes effect for requests presented in the cycle after the write edge. A request presented in the same cycle as the write is decoded with the old value.
- R9: When no request was presented in the previous cycle, req_valid_o and fwd_o are zero.
- R10: The mask register is written with wr_sel_i = 2'b00. A write with wr_sel_i = 2'b11 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request strobe |
| req_addr_i | input | 32 | CPU request address |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 00 mask, 01 mode, 10 fast back-to-back, 11 none |
| wr_data_i | input | 32 | Register write data |
| req_valid_o | output | 1 | Registered request strobe |
| fwd_o | output | 1 | Request is forwarded to PCI memory space |
| addr_o | output | 32 | Registered request address, unchanged |
| fbb_en_o | output | 2 | Fast back-to-back enable setting |

## Verification
The assertions assume that reset is released cleanly. They also assume that req_valid_i and wr_en_i are driven to known values in every cycle, and that req_addr_i is known whenever req_valid_i is high. Several checks compare a registered output against the value the inputs had one edge earlier. For that reason, the stimulus changes inputs only at falling edges and holds them through the next rising edge. The stimulus also lowers the strobes between operations, except in the one test that deliberately overlaps a mode write with a request to check the old-value rule.

// File: rtl/owd_pkg.sv
package owd_pkg;
  localparam int ADDR_W   = 32;
  localparam int TAG_W    = 4;
  localparam int IDX_W    = 5;
  localparam int NCHUNK   = 1 << IDX_W;
  localparam int IDX_LSB  = ADDR_W - TAG_W - IDX_W;
  localparam logic [TAG_W-1:0] WIN_TAG = 4'hF;
  localparam int MODE_LSB = 7;
  localparam int MODE_W   = 2;
  localparam logic [MODE_W-1:0] MODE_FWD = 2'b01;
  localparam int FBB_W    = 2;

  typedef enum logic [1:0] {
    SEL_MASK = 2'b00,
    SEL_MODE = 2'b01,
    SEL_FBB  = 2'b10,
    SEL_NONE = 2'b11
  } wr_sel_e;
endpackage

// File: rtl/owd_regs.sv
module owd_regs
  import owd_pkg::*;
#(
  parameter int DATA_W = ADDR_W,
  parameter int NCH    = NCHUNK,
  parameter int MLSB   = MODE_LSB,
  parameter int MW     = MODE_W,
  parameter int FW     = FBB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NCH-1:0]    mask_o,
  output logic [MW-1:0]     mode_o,
  output logic [FW-1:0]     fbb_o
);
  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      mode_o <= '0;
      fbb_o  <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_MASK: mask_o <= wr_data_i[NCH-1:0];
        SEL_MODE: mode_o <= wr_data_i[MLSB +: MW];
        SEL_FBB:  fbb_o  <= wr_data_i[FW-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/owd_chunk_decode.sv
module owd_chunk_decode
  import owd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int TW = TAG_W,
  parameter int IW = IDX_W,
  parameter logic [TW-1:0] TAG = WIN_TAG,
  parameter int MW = MODE_W,
  parameter logic [MW-1:0] MON = MODE_FWD
) (
  input  logic [AW-1:0]      addr_i,
  input  logic [(1<<IW)-1:0] mask_i,
  input  logic [MW-1:0]      mode_i,
  output logic               hit_o
);
  localparam int NCH = 1 << IW;
  localparam int LSB = AW - TW - IW;
  // end chunks are firmware and bridge registers
  localparam logic [NCH-1:0] KEEP = ~((NCH'(1) << (NCH-1)) | NCH'(1));

  logic [IW-1:0]  idx;
  logic [NCH-1:0] sel;
  logic [NCH-1:0] allow;
  logic           in_win;
  logic           mode_on;

  assign idx     = addr_i[LSB +: IW];
  assign in_win  = addr_i[AW-1 -: TW] == TAG;
  assign mode_on = mode_i == MON;
  assign allow   = mask_i & KEEP;

  for (genvar i = 0; i < NCH; i++) begin : g_chunk
    assign sel[i] = idx == IW'(i);
  end

  assign hit_o = in_win & mode_on & |(sel & allow);

  logic unused_lo;
  assign unused_lo = ^addr_i[LSB-1:0];
endmodule

// File: rtl/owd_out_stage.sv
module owd_out_stage
  import owd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          hit_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic          fwd_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fwd_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      fwd_o   <= valid_i & hit_i;
      if (valid_i) addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/owd_window_dec.sv
module owd_window_dec
  import owd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int FW = FBB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  output logic          req_valid_o,
  output logic          fwd_o,
  output logic [AW-1:0] addr_o,
  output logic [FW-1:0] fbb_en_o
);
  logic [NCHUNK-1:0] mask_q;
  logic [MODE_W-1:0] mode_q;
  logic              hit;

  owd_regs #(.DATA_W(AW), .NCH(NCHUNK), .MLSB(MODE_LSB), .MW(MODE_W), .FW(FW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .mask_o(mask_q), .mode_o(mode_q), .fbb_o(fbb_en_o)
  );

  owd_chunk_decode #(.AW(AW), .TW(TAG_W), .IW(IDX_W), .TAG(WIN_TAG), .MW(MODE_W), .MON(MODE_FWD)) u_dec (
    .addr_i(req_addr_i), .mask_i(mask_q), .mode_i(mode_q), .hit_o(hit)
  );

  owd_out_stage #(.AW(AW)) u_out (
    .clk_i, .rst_ni, .valid_i(req_valid_i), .hit_i(hit), .addr_i(req_addr_i),
    .valid_o(req_valid_o), .fwd_o, .addr_o
  );
endmodule

// File: rtl/owd_window_dec_chk.sv
module owd_window_dec_chk
  import owd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [FBB_W-1:0]  fbb_data_i,
  input logic [NCHUNK-1:0] mask_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              req_valid_o,
  input logic              fwd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [FBB_W-1:0]  fbb_en_o
);
  assert_addr_echo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> req_valid_o && addr_o == $past(req_addr_i));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !req_valid_o && !fwd_o);

  assert_outside_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> addr_o[ADDR_W-1 -: TAG_W] == WIN_TAG);

  assert_edge_chunks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> addr_o[IDX_LSB +: IDX_W] != '0 && addr_o[IDX_LSB +: IDX_W] != '1);

  assert_mask_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> $past(mask_i[req_addr_i[IDX_LSB +: IDX_W]]));

  assert_mode_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> $past(mode_i) == MODE_FWD);

  assert_fbb_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_FBB) |=> fbb_en_o == $past(fbb_data_i));

  assert_none_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_NONE) |=> $stable(fbb_en_o) && $stable(mask_i) && $stable(mode_i));
endmodule

bind owd_window_dec owd_window_dec_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .fbb_data_i(wr_data_i[owd_pkg::FBB_W-1:0]),
  .mask_i(mask_q), .mode_i(mode_q), .req_valid_o(req_valid_o), .fwd_o(fwd_o),
  .addr_o(addr_o), .fbb_en_o(fbb_en_o)
);

// File: tb/sim_owd_window_dec.sv
`timescale 1ns/1ps
module sim_owd_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid_o, fwd_o;
  logic [31:0] addr_o;
  logic [1:0]  fbb_en_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  owd_window_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .req_valid_o(req_valid_o), .fwd_o(fwd_o), .addr_o(addr_o), .fbb_en_o(fbb_en_o)
  );

  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] ctrl;
    logic [31:0] addr;
    logic        exp;
  } vec_t;

  // mode field is ctrl[8:7]; 0x80 -> 01 (on)
  localparam vec_t VECS [16] = '{
    '{32'hFFFF_FFFF, 32'h0000_0080, 32'hF080_0000, 1'b1},  // R3 chunk 1
    '{32'hFFFF_FFFF, 32'h0000_0080, 32'hFF00_0004, 1'b1},  // R3 chunk 30
    '{32'hFFFF_FFFF, 32'h0000_0080, 32'hFF80_0000, 1'b0},  // R5 chunk 31
    '{32'hFFFF_FFFF, 32'h0000_0080, 32'hF07F_FFFF, 1'b0},  // R5 chunk 0
    '{32'hFFFF_FFFF, 32'h0000_0080, 32'hE080_0000, 1'b0},  // R2 outside
    '{32'hFFFF_FFFF, 32'h0000_0080, 32'h7F80_0000, 1'b0},  // R2 outside
    '{32'hFFFF_FFFF, 32'h0000_0180, 32'hF080_0000, 1'b0},  // R4 mode 11
    '{32'hFFFF_FFFF, 32'h0000_0100, 32'hF080_0000, 1'b0},  // R4 mode 10
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hF080_0000, 1'b0},  // R4 mode 00
    '{32'hFFFF_FFFF, 32'hFFFF_FEFF, 32'hF080_0000, 1'b1},  // R4 other bits ignored
    '{32'h0000_0004, 32'h0000_0080, 32'hF100_0000, 1'b1},  // R3 chunk 2 only
    '{32'h0000_0004, 32'h0000_0080, 32'hF180_0000, 1'b0},  // R3 chunk 3 masked
    '{32'h8000_0001, 32'h0000_0080, 32'hF000_0000, 1'b0},  // R5 bit 0 ignored
    '{32'h8000_0001, 32'h0000_0080, 32'hFFFF_FFFC, 1'b0},  // R5 bit 31 ignored
    '{32'hAAAA_AAAA, 32'h0000_0080, 32'hF280_0000, 1'b1},  // R3 chunk 5
    '{32'hAAAA_AAAA, 32'h0000_0080, 32'hF200_0000, 1'b0}   // R3 chunk 4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req(input logic [31:0] a);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, req_valid_o}, 32'd0);
    check("R1 fwd", {31'd0, fwd_o}, 32'd0);
    check("R1 addr", addr_o, 32'd0);
    check("R1 fbb", {30'd0, fbb_en_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    req(32'hF080_0000);
    check("R1 no forward after reset", {31'd0, fwd_o}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      wr(2'b00, VECS[i].mask);
      wr(2'b01, VECS[i].ctrl);
      req(VECS[i].addr);
      check($sformatf("R3 vector %0d fwd", i), {31'd0, fwd_o}, {31'd0, VECS[i].exp});
      check($sformatf("R7 vector %0d addr", i), addr_o, VECS[i].addr);
      check("R7 valid", {31'd0, req_valid_o}, 32'd1);
    end

    @(negedge clk);
    check("R9 idle valid", {31'd0, req_valid_o}, 32'd0);
    check("R9 idle fwd", {31'd0, fwd_o}, 32'd0);

    wr(2'b10, 32'hFFFF_FFFF);
    check("R6 fbb low bits", {30'd0, fbb_en_o}, 32'd3);
    wr(2'b10, 32'h0000_0006);
    check("R6 fbb value 2", {30'd0, fbb_en_o}, 32'd2);

    wr(2'b00, 32'hFFFF_FFFF);
    wr(2'b01, 32'h0000_0080);
    wr(2'b11, 32'h0000_0000);
    check("R10 fbb unchanged", {30'd0, fbb_en_o}, 32'd2);
    req(32'hF400_0000);
    check("R10 mask and mode unchanged", {31'd0, fwd_o}, 32'd1);

    // mode write overlapping a request: request sees old mode
    wr_en = 1'b1; wr_sel = 2'b01; wr_data = 32'h0;
    req_valid = 1'b1; req_addr = 32'hF080_0000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R8 same-cycle uses old mode", {31'd0, fwd_o}, 32'd1);
    req(32'hF080_0000);
    check("R8 next cycle uses new mode", {31'd0, fwd_o}, 32'd0);

    wr(2'b01, 32'h0000_0080);
    wr_en = 1'b1; wr_sel = 2'b00; wr_data = 32'h0;
    req_valid = 1'b1; req_addr = 32'hF080_0000;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R8 same-cycle uses old mask", {31'd0, fwd_o}, 32'd1);
    req(32'hF080_0000);
    check("R8 next cycle uses new mask", {31'd0, fwd_o}, 32'd0);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears fbb", {30'd0, fbb_en_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    req(32'hF080_0000);
    check("R1 reset clears mode and mask", {31'd0, fwd_o}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule